// File: doc/BRIEF.md
# Watchdog Lockup Recovery Controller

This controller applies the recover-by-reboot policy after a processor hang. It watches the timeout pulses from an external watchdog counter. The first timeout is only remembered. The second timeout sets a sticky lockup status flag, raises one alert message request and, once that alert is accepted, pulses a CPU reboot request.

Firmware is expected to clear the status flag after a successful restart, and the clear silences the controller. If a third timeout arrives while the flag is still set, the reboot is taken to have failed. The controller then makes no further reboot attempts and instead sends an alert once every period, with no end. The periodic alerts do not depend on the power state or on the policy enable, so they continue through a forced soft-off and a later wake. They stop only on a status clear or a full reset.

The period comes from a prescaler followed by a tick counter. Both terminal counts are parameters: the defaults give a period of about 31 seconds at 200 MHz, and a simulation can use a much shorter period. Timeouts are counted only while the system is fully on and the policy is enabled.

Top module: `lockup_recovery_ctrl`

## Requirements
- R1: After reset, `reboot_req_o`, `msg_req_o` and `lockup_sts_o` are low and the stored timeout count is zero.
- R2: A single qualified timeout, where a timeout is qualified when `wdt_expire_i`, `pwr_full_on_i` and `policy_en_i` are all high, changes no output.
- R3: The second qualified timeout sets `lockup_sts_o` and raises `msg_req_o` in the cycle after the one in which it is sampled. Exactly one alert is requested for it.
- R4: Once raised, `msg_req_o` stays high until `msg_ack_i` is sampled high, and it is low in the following cycle unless a new alert is due in that same cycle.
- R5: `reboot_req_o` is a one-cycle pulse in the cycle after the first alert is accepted. It occurs only once per lockup episode.
- R6: A timeout that arrives while `pwr_full_on_i` or `policy_en_i` is low is not counted.
- R7: A qualified timeout that arrives after the reboot pulse, while `lockup_sts_o` is still set, produces no reboot. It raises `msg_req_o` in the next cycle and starts periodic alerting.
- R8: In periodic alerting, a new alert is raised every TICK_DIV*PERIOD_TICKS cycles, counted from the first periodic alert.
- R9: Periodic alerting continues whatever the values of `pwr_full_on_i` and `policy_en_i`.
- R10: `sts_clear_i` drops `lockup_sts_o` and `msg_req_o` in the next cycle, stops all alerts and clears the timeout count, so that the next qualified timeout counts as the first.
- R11: Timeouts that arrive while the first alert is pending, or during the reboot pulse, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wdt_expire_i | input | 1 | One-cycle pulse from the watchdog counter when it times out |
| sts_clear_i | input | 1 | Firmware write that clears the lockup status flag |
| pwr_full_on_i | input | 1 | High while the system is in the fully-on power state |
| policy_en_i | input | 1 | High when reboot-on-lockup is enabled |
| msg_ack_i | input | 1 | The message sender has accepted the pending alert |
| reboot_req_o | output | 1 | One-cycle CPU reboot request |
| msg_req_o | output | 1 | Alert message request, held until acknowledged |
| lockup_sts_o | output | 1 | Sticky lockup status flag |

## Verification
The bound checker tests the cycle-level rules on every cycle. The reboot pulse lasts exactly one cycle, follows an accepted alert and needs the status flag. An alert request holds until it is acknowledged. The status flag is sticky until cleared, and a clear empties both the flag and the request. Some behaviours can only be shown by the bench's scenarios, because they depend on how many timeouts came before or on the length of a time window. These are that the first timeout is silent, that unqualified timeouts are not counted, that a third timeout brings no second reboot, that the alert period has its exact length, and that alerting goes on after the power state and the enable are removed. A cycle-accurate reference model driven by random stimulus covers the orderings between these cases.

// File: rtl/lkr_pkg.sv
package lkr_pkg;
  typedef enum logic [2:0] {
    LK_IDLE     = 3'd0,
    LK_ALERT    = 3'd1,
    LK_REBOOT   = 3'd2,
    LK_ARMED    = 3'd3,
    LK_PERIODIC = 3'd4
  } lk_state_e;
endpackage

// File: rtl/lkr_rst_sync.sv
module lkr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lkr_period_timer.sv
module lkr_period_timer #(
  parameter int TICK_DIV     = 200_000_000,
  parameter int PERIOD_TICKS = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic fire_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PER_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_TICKS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             tick;
  logic             cnt_en;

  always_comb begin
    tick   = en_i && (pre_q == PRE_LAST);
    pre_d  = pre_q;
    per_d  = per_q;
    if (!en_i) begin
      pre_d = '0;
      per_d = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      if (tick) per_d = (per_q == PER_LAST) ? '0 : per_q + PER_W'(1);
    end
    cnt_en = en_i || (pre_q != '0) || (per_q != '0);
    fire_o = tick && (per_q == PER_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else if (cnt_en) begin
      pre_q <= pre_d;
      per_q <= per_d;
    end
  end
endmodule

// File: rtl/lkr_msg_hold.sv
module lkr_msg_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q, pend_d, upd_en;

  always_comb begin
    pend_d = pend_q;
    if (clr_i)      pend_d = 1'b0;
    else if (set_i) pend_d = 1'b1;
    else if (ack_i) pend_d = 1'b0;
    upd_en = clr_i || set_i || ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/lkr_fsm.sv
module lkr_fsm
  import lkr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wdt_expire_i,
  input  logic      sts_clear_i,
  input  logic      apply_i,
  input  logic      msg_ack_i,
  input  logic      msg_pend_i,
  input  logic      period_fire_i,
  output lk_state_e state_o,
  output logic      sts_o,
  output logic      msg_set_o,
  output logic      msg_clr_o,
  output logic      reboot_o
);
  lk_state_e state_q, state_d;
  logic      seen_q, seen_d;
  logic      sts_q, sts_d;
  logic      qual_to;

  always_comb begin
    qual_to   = wdt_expire_i && apply_i;
    state_d   = state_q;
    seen_d    = seen_q;
    sts_d     = sts_q;
    msg_set_o = 1'b0;
    msg_clr_o = 1'b0;
    if (sts_clear_i) begin
      state_d   = LK_IDLE;
      seen_d    = 1'b0;
      sts_d     = 1'b0;
      msg_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        LK_IDLE: begin
          if (qual_to) begin
            if (seen_q) begin
              state_d   = LK_ALERT;
              sts_d     = 1'b1;
              seen_d    = 1'b0;
              msg_set_o = 1'b1;
            end else begin
              seen_d = 1'b1;
            end
          end
        end
        LK_ALERT:  if (msg_ack_i && msg_pend_i) state_d = LK_REBOOT;
        LK_REBOOT: state_d = LK_ARMED;
        LK_ARMED: begin
          if (qual_to) begin
            state_d   = LK_PERIODIC;
            msg_set_o = 1'b1;
          end
        end
        LK_PERIODIC: if (period_fire_i) msg_set_o = 1'b1;
        default: state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      seen_q  <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      sts_q   <= sts_d;
    end
  end

  assign state_o  = state_q;
  assign sts_o    = sts_q;
  assign reboot_o = (state_q == LK_REBOOT);
endmodule

// File: rtl/lockup_recovery_ctrl.sv
module lockup_recovery_ctrl
  import lkr_pkg::*;
#(
  parameter int TICK_DIV     = 200_000_000,
  parameter int PERIOD_TICKS = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_expire_i,
  input  logic sts_clear_i,
  input  logic pwr_full_on_i,
  input  logic policy_en_i,
  input  logic msg_ack_i,
  output logic reboot_req_o,
  output logic msg_req_o,
  output logic lockup_sts_o
);
  logic      rst_core_n;
  lk_state_e state;
  logic      msg_set, msg_clr, msg_pend, period_fire;

  lkr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  lkr_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .wdt_expire_i  (wdt_expire_i),
    .sts_clear_i   (sts_clear_i),
    .apply_i       (pwr_full_on_i && policy_en_i),
    .msg_ack_i     (msg_ack_i),
    .msg_pend_i    (msg_pend),
    .period_fire_i (period_fire),
    .state_o       (state),
    .sts_o         (lockup_sts_o),
    .msg_set_o     (msg_set),
    .msg_clr_o     (msg_clr),
    .reboot_o      (reboot_req_o)
  );

  lkr_period_timer #(.TICK_DIV(TICK_DIV), .PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .en_i   (state == LK_PERIODIC),
    .fire_o (period_fire)
  );

  lkr_msg_hold u_msg (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set_i  (msg_set),
    .clr_i  (msg_clr),
    .ack_i  (msg_ack_i),
    .pend_o (msg_pend)
  );

  assign msg_req_o = msg_pend;
endmodule

// File: rtl/lkr_checker.sv
module lkr_checker (
  input logic clk,
  input logic rst_n,
  input logic sts_clear_i,
  input logic msg_ack_i,
  input logic reboot_req_o,
  input logic msg_req_o,
  input logic lockup_sts_o
);
  AST_REBOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req_o |=> !reboot_req_o); // R5
  AST_REBOOT_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req_o |-> lockup_sts_o); // R5
  AST_REBOOT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req_o |-> $past(msg_req_o && msg_ack_i)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req_o && !msg_ack_i && !sts_clear_i) |=> msg_req_o); // R4
  AST_MSG_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req_o |-> lockup_sts_o); // R3
  AST_STS_RISE_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockup_sts_o) |-> msg_req_o); // R3
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clear_i |=> (!lockup_sts_o && !msg_req_o)); // R10
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lockup_sts_o && !sts_clear_i) |=> lockup_sts_o); // R10
endmodule

bind lockup_recovery_ctrl lkr_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sts_clear_i  (sts_clear_i),
  .msg_ack_i    (msg_ack_i),
  .reboot_req_o (reboot_req_o),
  .msg_req_o    (msg_req_o),
  .lockup_sts_o (lockup_sts_o)
);

// File: tb/lockup_recovery_ctrl_tb_top.sv
`timescale 1ns/1ps
module lockup_recovery_ctrl_tb_top;
  localparam int TDIV = 4;
  localparam int PTK  = 5;
  localparam int NPER = TDIV * PTK;

  logic clk, rst_n;
  logic wdt, clr, pwr, pol, ack;
  logic reboot, msg, sts;

  int n_chk, n_fail;
  bit done;

  int m_mode, m_pc;
  bit m_seen, m_sts, m_pend;

  lockup_recovery_ctrl #(.TICK_DIV(TDIV), .PERIOD_TICKS(PTK)) dut_i (
    .clk(clk), .rst_n(rst_n), .wdt_expire_i(wdt), .sts_clear_i(clr),
    .pwr_full_on_i(pwr), .policy_en_i(pol), .msg_ack_i(ack),
    .reboot_req_o(reboot), .msg_req_o(msg), .lockup_sts_o(sts));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_mode = 0; m_pc = 0; m_seen = 0; m_sts = 0; m_pend = 0;
  endfunction

  // Reference model built from the requirements (modes: 0 idle, 1 alert, 2 reboot, 3 armed, 4 periodic)
  function automatic void model_step(input bit t, input bit c, input bit p, input bit e, input bit a);
    bit set = 0;
    bit qual = t && p && e;
    bit old_pend = m_pend;
    if (c) begin
      model_reset();
      return;
    end
    case (m_mode)
      0: if (qual) begin
           if (m_seen) begin m_mode = 1; m_sts = 1; set = 1; m_seen = 0; end
           else m_seen = 1;
         end
      1: if (a && old_pend) m_mode = 2;
      2: m_mode = 3;
      3: if (qual) begin m_mode = 4; set = 1; m_pc = 0; end
      4: if (m_pc == NPER - 1) begin set = 1; m_pc = 0; end else m_pc++;
      default: m_mode = 0;
    endcase
    if (set) m_pend = 1;
    else if (a) m_pend = 0;
  endfunction

  task automatic cyc(input bit t, input bit c, input bit p, input bit e, input bit a);
    @(negedge clk);
    wdt = t; clr = c; pwr = p; pol = e; ack = a;
    @(posedge clk);
    #1;
    model_step(t, c, p, e, a);
    chk("R5 model reboot", reboot, m_mode == 2);
    chk("R4 model msg", msg, m_pend);
    chk("R3 model sts", sts, m_sts);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1ac3_5eed));
    n_chk = 0; n_fail = 0; done = 0;
    wdt = 0; clr = 0; pwr = 1; pol = 1; ack = 0; rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reboot", reboot, 0);
    chk("R1 msg", msg, 0);
    chk("R1 sts", sts, 0);
    @(negedge clk); rst_n = 1;
    idle(4);

    // R6: unqualified timeouts are not counted
    cyc(1, 0, 0, 1, 0); cyc(1, 0, 1, 0, 0); cyc(1, 0, 0, 0, 0);
    idle(2);
    chk("R6 sts", sts, 0);
    // R2: first qualified timeout is silent
    cyc(1, 0, 1, 1, 0);
    chk("R2 sts", sts, 0); chk("R2 msg", msg, 0);
    idle(3);
    chk("R2 reboot", reboot, 0);
    // R3: second qualified timeout
    cyc(1, 0, 1, 1, 0);
    chk("R3 sts", sts, 1); chk("R3 msg", msg, 1);
    // R11: timeouts while alert pending ignored; R4 hold
    cyc(1, 0, 1, 1, 0); cyc(1, 0, 1, 1, 0);
    idle(3);
    chk("R4 hold", msg, 1); chk("R11 reboot", reboot, 0);
    cyc(0, 0, 1, 1, 1);
    chk("R4 drop", msg, 0); chk("R5 pulse", reboot, 1);
    cyc(1, 0, 1, 1, 0);
    chk("R5 single", reboot, 0); chk("R11 msg", msg, 0);
    idle(5);
    chk("R3 one alert", msg, 0); chk("R5 once", reboot, 0);
    // R10: clear then count restarts
    cyc(0, 1, 1, 1, 0);
    chk("R10 sts", sts, 0);
    cyc(1, 0, 1, 1, 0);
    chk("R10 count cleared", sts, 0);
    cyc(0, 1, 1, 1, 0);

    // Escalation to periodic
    cyc(1, 0, 1, 1, 0); cyc(1, 0, 1, 1, 0);
    cyc(0, 0, 1, 1, 1);
    chk("R5 pulse2", reboot, 1);
    idle(2);
    cyc(1, 0, 1, 1, 0);
    chk("R7 msg", msg, 1); chk("R7 no reboot", reboot, 0);
    cyc(0, 0, 1, 1, 1);
    chk("R7 acked", msg, 0);
    for (int i = 0; i < NPER - 2; i++) cyc(0, 0, 1, 1, 0);
    chk("R8 early", msg, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R8 on time", msg, 1);
    cyc(0, 0, 0, 0, 1);
    // R9: power off and policy off, alerting continues
    for (int i = 0; i < NPER - 2; i++) cyc(1, 0, 0, 0, 0);
    chk("R9 early", msg, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R9 continues", msg, 1); chk("R9 sts", sts, 1); chk("R7 no reboot2", reboot, 0);
    cyc(0, 1, 0, 0, 0);
    chk("R10 msg", msg, 0); chk("R10 sts2", sts, 0);
    for (int i = 0; i < 3 * NPER; i++) cyc(0, 0, 1, 1, 0);
    chk("R10 silent", msg, 0);

    // Random mix compared against the reference model
    for (int i = 0; i < 6000; i++)
      cyc(($urandom % 6) == 0, ($urandom % 60) == 0, ($urandom % 8) != 0,
          ($urandom % 10) != 0, ($urandom % 3) == 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule